// File: doc/BRIEF.md
# Nine-bit multidrop serial receiver with address filter

This block receives asynchronous serial characters of nine data bits, as used on shared multidrop lines where the ninth bit marks a character as an address. It samples the line with a 16x oversampling tick, rebuilds each character and hands it downstream on a valid/ready port. Each delivered character also gives a one-cycle receive interrupt pulse.

An address-filter enable lets a node sleep through traffic meant for others. While the filter is on, only characters with the ninth bit set get through. External logic compares the delivered address with its own and clears the enable to take the data that follows. The block never turns the filter off by itself. A change to the enable takes effect only between characters.

The output port holds one character. Back-pressure rules: `rx_valid` stays high and `rx_data` stays still until `rx_ready` is seen high at a clock edge. A character that completes while the held word is still waiting, and is not being taken in that same cycle, is discarded. It gives no interrupt. The serial line cannot be stalled.

Top module: `mdrop_rx9`

## Requirements
- R1: The frame is one low start bit, nine data bits with the least significant bit first, and one high stop bit. Each data bit is sampled once, at its centre, 16 ticks after the previous sample. The character is delivered as `rx_data[8:0]`.
- R2: A start is accepted only if the line is still low on the eighth tick after the low level was first seen. A shorter low pulse produces no character and no framing error.
- R3: A stop bit sampled low gives a one-cycle `frame_err` pulse. The character is dropped: no valid and no interrupt.
- R4: With the filter off, every correctly framed character is delivered, whatever the value of bit 8.
- R5: With the filter on, a character whose bit 8 is 0 is discarded. It raises neither `rx_valid` nor `rx_irq`.
- R6: With the filter on, a character whose bit 8 is 1 is delivered with `rx_valid` and an `rx_irq` pulse.
- R7: The filter stays on after an address character passes. Once the enable is driven low from outside, all characters pass.
- R8: The filter setting used for a character is the enable level when the receiver was idle before that character's start bit. Changing the enable during the character has no effect on it.
- R9: After reset, no start is recognised until the line has been high for 16 consecutive ticks.
- R10: `rx_valid` and `rx_data` hold steady while `rx_ready` is low. A character completing while the slot is still occupied is dropped.
- R11: `rx_irq` is a one-cycle pulse, asserted in the first cycle `rx_valid` is high for each loaded character. There is exactly one pulse per loaded character.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rxd | input | 1 | Serial receive line, idle high |
| os_tick | input | 1 | One-cycle strobe at 16 times the bit rate |
| addr_filt_en | input | 1 | Address filter enable; takes effect between characters |
| rx_ready | input | 1 | Downstream can take the held character |
| rx_data | output | 9 | Received character; bit 8 is the address flag |
| rx_valid | output | 1 | A character is held on `rx_data` |
| rx_irq | output | 1 | One-cycle pulse when a character is loaded |
| frame_err | output | 1 | One-cycle pulse on a low stop bit |

## Verification
A wrong sample counter or bit index shows up as a shifted or scrambled word on the first character after the fault. A stuck state in the framer shows up as a character that never arrives, or as a spurious framing pulse about one frame time later. A filter flag that is latched at the wrong moment, or that clears itself, changes which characters reach the port. The next character with bit 8 at 0 exposes it. A slip in the output slot logic shows as moving data under back-pressure, or as interrupt counts that differ from the delivered words.

// File: rtl/mdrop_rx9_pkg.sv
package mdrop_rx9_pkg;
  typedef enum logic [1:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_STOP
  } rx_state_e;
endpackage

// File: rtl/rx9_sync.sv
// Line synchroniser plus post-reset arming: the line must be seen high
// for OS_RATE consecutive ticks before any start edge is honoured.
module rx9_sync #(
  parameter int OS_RATE     = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rxd,
  input  logic os_tick,
  output logic rxd_s,
  output logic armed
);
  localparam int CW = $clog2(OS_RATE);

  logic [SYNC_STAGES-1:0] chain_q;
  logic [CW-1:0]          high_cnt_q;
  logic                   armed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '1;
    else        chain_q <= {chain_q[SYNC_STAGES-2:0], rxd};
  end

  assign rxd_s = chain_q[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      high_cnt_q <= '0;
      armed_q    <= 1'b0;
    end else if (!armed_q) begin
      if (!rxd_s) begin
        high_cnt_q <= '0;
      end else if (os_tick) begin
        if (high_cnt_q == CW'(OS_RATE - 1)) armed_q <= 1'b1;
        else                                high_cnt_q <= high_cnt_q + 1'b1;
      end
    end
  end

  assign armed = armed_q;
endmodule

// File: rtl/rx9_framer.sv
// Start confirmation, centre sampling of the data bits, stop check.
module rx9_framer
  import mdrop_rx9_pkg::*;
#(
  parameter int OS_RATE   = 16,
  parameter int DATA_BITS = 9
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 os_tick,
  input  logic                 rxd_s,
  input  logic                 armed,
  output logic                 busy,
  output logic                 done,
  output logic                 ferr,
  output logic [DATA_BITS-1:0] word
);
  localparam int CW   = $clog2(OS_RATE);
  localparam int BW   = $clog2(DATA_BITS + 1);
  localparam int HALF = OS_RATE / 2;

  rx_state_e            st_q;
  logic [CW-1:0]        cnt_q;
  logic [BW-1:0]        bit_q;
  logic [DATA_BITS-1:0] shift_q;
  logic                 done_q, ferr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= RX_IDLE;
      cnt_q   <= '0;
      bit_q   <= '0;
      shift_q <= '0;
      done_q  <= 1'b0;
      ferr_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      ferr_q <= 1'b0;
      if (os_tick) begin
        case (st_q)
          RX_IDLE: begin
            cnt_q <= '0;
            if (armed && !rxd_s) st_q <= RX_START;
          end
          RX_START: begin
            if (cnt_q == CW'(HALF - 1)) begin
              cnt_q <= '0;
              bit_q <= '0;
              st_q  <= rxd_s ? RX_IDLE : RX_DATA;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          RX_DATA: begin
            if (cnt_q == CW'(OS_RATE - 1)) begin
              cnt_q   <= '0;
              shift_q <= {rxd_s, shift_q[DATA_BITS-1:1]};
              if (bit_q == BW'(DATA_BITS - 1)) st_q  <= RX_STOP;
              else                             bit_q <= bit_q + 1'b1;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          RX_STOP: begin
            if (cnt_q == CW'(OS_RATE - 1)) begin
              cnt_q  <= '0;
              st_q   <= RX_IDLE;
              done_q <= rxd_s;
              ferr_q <= !rxd_s;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          default: st_q <= RX_IDLE;
        endcase
      end
    end
  end

  assign busy = (st_q != RX_IDLE);
  assign done = done_q;
  assign ferr = ferr_q;
  assign word = shift_q;
endmodule

// File: rtl/rx9_filter.sv
// Address filter latched at character boundaries plus one-word output slot.
module rx9_filter #(
  parameter int DATA_BITS = 9
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 busy,
  input  logic                 done,
  input  logic [DATA_BITS-1:0] word,
  input  logic                 filt_en,
  input  logic                 rx_ready,
  output logic [DATA_BITS-1:0] rx_data,
  output logic                 rx_valid,
  output logic                 rx_irq,
  output logic                 filt_active
);
  localparam int ADDR_BIT = DATA_BITS - 1;

  logic                 filt_q, vld_q, irq_q;
  logic [DATA_BITS-1:0] data_q;
  logic                 pass, slot_free;

  // Filter setting only moves while no character is being shifted in.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     filt_q <= 1'b0;
    else if (!busy) filt_q <= filt_en;
  end

  assign pass      = done && (!filt_q || word[ADDR_BIT]);
  assign slot_free = !vld_q || rx_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      irq_q  <= 1'b0;
      data_q <= '0;
    end else begin
      irq_q <= 1'b0;
      if (vld_q && rx_ready) vld_q <= 1'b0;
      if (pass && slot_free) begin
        data_q <= word;
        vld_q  <= 1'b1;
        irq_q  <= 1'b1;
      end
    end
  end

  assign rx_data     = data_q;
  assign rx_valid    = vld_q;
  assign rx_irq      = irq_q;
  assign filt_active = filt_q;
endmodule

// File: rtl/mdrop_rx9.sv
module mdrop_rx9 #(
  parameter int OS_RATE     = 16,
  parameter int DATA_BITS   = 9,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 rxd,
  input  logic                 os_tick,
  input  logic                 addr_filt_en,
  input  logic                 rx_ready,
  output logic [DATA_BITS-1:0] rx_data,
  output logic                 rx_valid,
  output logic                 rx_irq,
  output logic                 frame_err
);
  logic                 rxd_s, armed, busy, done;
  logic [DATA_BITS-1:0] word;
  logic                 filt_active;

  rx9_sync #(.OS_RATE(OS_RATE), .SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .rxd(rxd), .os_tick(os_tick),
    .rxd_s(rxd_s), .armed(armed)
  );

  rx9_framer #(.OS_RATE(OS_RATE), .DATA_BITS(DATA_BITS)) u_framer (
    .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .rxd_s(rxd_s),
    .armed(armed), .busy(busy), .done(done), .ferr(frame_err), .word(word)
  );

  rx9_filter #(.DATA_BITS(DATA_BITS)) u_filter (
    .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .word(word),
    .filt_en(addr_filt_en), .rx_ready(rx_ready), .rx_data(rx_data),
    .rx_valid(rx_valid), .rx_irq(rx_irq), .filt_active(filt_active)
  );
endmodule

// File: rtl/mdrop_rx9_chk.sv
module mdrop_rx9_chk #(
  parameter int DATA_BITS = 9
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 rx_valid,
  input logic                 rx_ready,
  input logic [DATA_BITS-1:0] rx_data,
  input logic                 rx_irq,
  input logic                 frame_err,
  input logic                 filt_active
);
  // R10
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && !rx_ready |=> rx_valid && $stable(rx_data));

  // R11
  irq_with_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_irq |-> rx_valid);

  // R11
  irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_irq |=> !rx_irq);

  // R3
  ferr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err |=> !frame_err);

  // R3
  ferr_no_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err |-> !rx_irq);

  // R5
  filt_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_irq && $past(filt_active) |-> rx_data[DATA_BITS-1]);
endmodule

bind mdrop_rx9 mdrop_rx9_chk #(.DATA_BITS(DATA_BITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_ready(rx_ready),
  .rx_data(rx_data), .rx_irq(rx_irq), .frame_err(frame_err),
  .filt_active(filt_active)
);

// File: tb/test_mdrop_rx9.sv
module test_mdrop_rx9;
  localparam int CLK_PERIOD = 10;
  localparam int TICK_DIV   = 2;
  localparam int BIT_CLKS   = 16 * TICK_DIV;

  logic       clk = 1'b0, rst_n = 1'b0, rxd = 1'b0, os_tick = 1'b0;
  logic       addr_filt_en = 1'b0, rx_ready = 1'b1;
  logic [8:0] rx_data;
  logic       rx_valid, rx_irq, frame_err;

  int checks = 0, errors = 0;
  int out_cnt = 0, irq_seen = 0, irq_exp = 0, ferr_seen = 0, ferr_exp = 0;
  logic [8:0] exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) os_tick <= ~os_tick;

  mdrop_rx9 i_mdrop_rx9 (
    .clk(clk), .rst_n(rst_n), .rxd(rxd), .os_tick(os_tick),
    .addr_filt_en(addr_filt_en), .rx_ready(rx_ready), .rx_data(rx_data),
    .rx_valid(rx_valid), .rx_irq(rx_irq), .frame_err(frame_err)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_clks(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  // Driver: one frame on the line, optional enable change at a data bit.
  task automatic xmit(input logic [8:0] w, input bit stop_hi, input bit exp_pass,
                      input int chg_at, input bit chg_val);
    if (exp_pass) begin
      exp_q.push_back(w);
      irq_exp++;
    end
    if (!stop_hi) ferr_exp++;
    rxd = 1'b0;
    wait_clks(BIT_CLKS);
    for (int i = 0; i < 9; i++) begin
      if (i == chg_at) addr_filt_en = chg_val;
      rxd = w[i];
      wait_clks(BIT_CLKS);
    end
    if (stop_hi) begin
      rxd = 1'b1;
      wait_clks(BIT_CLKS);
    end else begin
      rxd = 1'b0;
      wait_clks(BIT_CLKS/2 + 12);
      rxd = 1'b1;
      wait_clks(2 * BIT_CLKS);
    end
    wait_clks(BIT_CLKS);
  endtask

  function automatic bit passes(input logic [8:0] w);
    return !addr_filt_en || w[8];
  endfunction

  // Monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (rx_irq) irq_seen++;
      if (frame_err) ferr_seen++;
      if (rx_valid && rx_ready) begin
        out_cnt++;
        if (exp_q.size() == 0) begin
          chk(1'b0, "R1 unexpected word", int'(rx_data), 0);
        end else begin
          logic [8:0] e;
          e = exp_q.pop_front();
          chk(rx_data == e, "R1/R4/R6 word", int'(rx_data), int'(e));
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int oc, ic, fc;
    // Reset with the line held low (not idle)
    wait_clks(5);
    chk(rx_valid == 1'b0, "R10 reset valid", rx_valid, 0);
    chk(rx_irq == 1'b0, "R11 reset irq", rx_irq, 0);
    chk(frame_err == 1'b0, "R3 reset ferr", frame_err, 0);
    rst_n = 1'b1;

    // R9: low line and short high after reset must not start a frame
    wait_clks(100);
    rxd = 1'b1; wait_clks(10);
    rxd = 1'b0; wait_clks(200);
    rxd = 1'b1; wait_clks(3 * BIT_CLKS);
    chk(out_cnt == 0 && ferr_seen == 0, "R9 no start before arming", out_cnt + ferr_seen, 0);

    // R1, R4: filter off, both address and data characters pass
    xmit(9'h0A5, 1, 1, -1, 0);
    xmit(9'h15A, 1, 1, -1, 0);
    xmit(9'h000, 1, 1, -1, 0);
    xmit(9'h1FF, 1, 1, -1, 0);
    chk(out_cnt == 4, "R4 all delivered", out_cnt, 4);

    // R2: short low glitch
    oc = out_cnt; fc = ferr_seen;
    rxd = 1'b0; wait_clks(6);
    rxd = 1'b1; wait_clks(2 * BIT_CLKS);
    chk(out_cnt == oc && ferr_seen == fc, "R2 glitch ignored", out_cnt - oc + ferr_seen - fc, 0);

    // R3: low stop bit
    oc = out_cnt;
    xmit(9'h055, 0, 0, -1, 0);
    chk(out_cnt == oc, "R3 bad frame dropped", out_cnt, oc);
    chk(ferr_seen == ferr_exp, "R3 framing pulse", ferr_seen, ferr_exp);

    // R5, R6: filter on
    addr_filt_en = 1'b1;
    wait_clks(4);
    oc = out_cnt; ic = irq_seen;
    xmit(9'h0AA, 1, passes(9'h0AA), -1, 0);
    chk(out_cnt == oc && irq_seen == ic, "R5 data dropped", out_cnt - oc + irq_seen - ic, 0);
    xmit(9'h1AA, 1, passes(9'h1AA), -1, 0);
    chk(out_cnt == oc + 1, "R6 address passed", out_cnt, oc + 1);

    // R7: still filtering after an address, then cleared externally
    oc = out_cnt;
    xmit(9'h033, 1, passes(9'h033), -1, 0);
    chk(out_cnt == oc, "R7 filter persists", out_cnt, oc);
    addr_filt_en = 1'b0;
    wait_clks(4);
    xmit(9'h033, 1, passes(9'h033), -1, 0);
    chk(out_cnt == oc + 1, "R7 pass after clear", out_cnt, oc + 1);

    // R8: enable changes during a character do not affect it
    oc = out_cnt;
    xmit(9'h044, 1, passes(9'h044), 3, 1'b1);
    chk(out_cnt == oc + 1, "R8 set mid-char", out_cnt, oc + 1);
    xmit(9'h066, 1, passes(9'h066), 3, 1'b0);
    chk(out_cnt == oc + 1, "R8 clear mid-char", out_cnt, oc + 1);
    xmit(9'h011, 1, passes(9'h011), -1, 0);
    chk(out_cnt == oc + 2, "R8 next char uses new", out_cnt, oc + 2);

    // R10: back-pressure, second character dropped while slot full
    rx_ready = 1'b0;
    xmit(9'h1C3, 1, 1, -1, 0);
    xmit(9'h0F0, 1, 0, -1, 0);
    chk(rx_valid == 1'b1, "R10 held valid", rx_valid, 1);
    chk(rx_data == 9'h1C3, "R10 held data", int'(rx_data), 'h1C3);
    rx_ready = 1'b1;
    wait_clks(BIT_CLKS);

    // Wrap-up
    wait_clks(4 * BIT_CLKS);
    chk(exp_q.size() == 0, "R1 all expected words seen", exp_q.size(), 0);
    chk(irq_seen == irq_exp, "R11 irq count", irq_seen, irq_exp);
    chk(ferr_seen == ferr_exp, "R3 ferr count", ferr_seen, ferr_exp);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule